// File: doc/BRIEF.md
# Hybrid Full/Half-Bridge Speed Mixer

This block chooses, once per drive period, whether the motor bridges run in full-bridge mode (both outputs of a phase toggle in antiphase, so the load sees twice the supply swing) or in half-bridge mode (the inverted output stays low, so the load sees one supply swing). Interleaving the two modes sets the average drive level anywhere between one and two times the supply. The level follows supply × (1 + k/128), where k is an 8-bit speed setting from 0 to 128.

A 7-bit phase accumulator adds k on every mixed period. A period runs full-bridge when the sum carries out of the accumulator. This spreads the full-bridge periods as evenly as the ratio allows. A supply-threshold comparator flag, gated by a half-bridge enable, forces every period to half-bridge. An idle control suppresses drive while keeping the accumulator state. Every decision is sampled and registered on the period tick, so a mode never changes inside a period.

Top module: `hybrid_bridge_mixer`

## Requirements
- R1: After reset, `drive_on` is 0, `full_mode` is 1 and the stored speed setting is 128. With hybrid mixing enabled and no speed write, every period is full-bridge.
- R2: A write with `speed_we` high stores `speed_wdata`. When mixing with a setting k from 1 to 127, the period that brings the running total of k past a multiple of 128 is full-bridge (`full_mode`=1); all other periods are half-bridge (`full_mode`=0). Any 128 consecutive mixed periods therefore hold exactly k full-bridge periods.
- R3: A setting of 0 gives half-bridge on every mixed period, and a setting of 128 gives full-bridge on every mixed period.
- R4: A stored value above 128 acts exactly as 128 and does not advance the accumulator.
- R5: With `hybrid_en` low (and no forced half-bridge), every driven period is full-bridge, and the accumulator does not advance.
- R6: With `half_en` and `supply_high` both high, every driven period is half-bridge whatever the hybrid setting, and the accumulator does not advance. Either signal alone has no effect.
- R7: A tick taken with `idle` high sets `drive_on` to 0 and keeps `full_mode` and the accumulator unchanged, so the mixed sequence resumes where it stopped.
- R8: `drive_on` and `full_mode` change only at a rising clock edge where `period_tick` is high, and take their new values right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse at each drive period boundary |
| speed_we | input | 1 | Write strobe for the speed setting |
| speed_wdata | input | 8 | New speed setting (0..128, larger values clamp) |
| hybrid_en | input | 1 | Enables full/half-bridge mixing |
| half_en | input | 1 | Allows the supply comparator to force half-bridge |
| supply_high | input | 1 | Supply-above-threshold comparator flag |
| idle | input | 1 | Suppresses drive, keeps accumulator state |
| drive_on | output | 1 | Bridges active for the current period |
| full_mode | output | 1 | 1 = full-bridge period, 0 = half-bridge period |

## Verification
The assertions assume `period_tick` is a clean pulse that is valid at the clock edge. They also assume the control levels are stable at the tick edge; between ticks they may change freely. The stimulus changes every input at the falling edge and raises the tick for exactly one cycle. It also toggles controls and writes the speed setting during gaps between ticks, to show that such changes stay invisible until the next boundary.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    localparam int unsigned SPEED_W    = 8;
    localparam int unsigned FULL_SCALE = 128;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_FULL = 1'b1
    } bridge_mode_e;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_FORCED,
        SRC_FIXED,
        SRC_MIX
    } mode_src_e;

    typedef struct packed {
        logic idle;
        logic half_en;
        logic supply_high;
        logic hybrid_en;
    } mix_ctrl_t;

    function automatic logic [SPEED_W-1:0] clamp_speed(
        input logic [SPEED_W-1:0] raw,
        input logic [SPEED_W-1:0] limit
    );
        return (raw > limit) ? limit : raw;
    endfunction

endpackage

// File: rtl/hbm_speed_reg.sv
module hbm_speed_reg
    import hbm_pkg::*;
#(
    parameter int unsigned W  = SPEED_W,
    parameter int unsigned FS = FULL_SCALE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] speed_eff,
    output logic         at_full_scale
);
    localparam logic [W-1:0] FS_VAL = W'(FS);

    logic [W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst)     raw_q <= FS_VAL;
        else if (we) raw_q <= wdata;
    end

    assign speed_eff     = clamp_speed(raw_q, FS_VAL);
    assign at_full_scale = (speed_eff == FS_VAL);

    // R1: first cycle out of reset holds the full-scale setting
    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == FS_VAL));

    // R2: a write lands in the register on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (raw_q == $past(wdata)));

endmodule

// File: rtl/hbm_phase_acc.sv
module hbm_phase_acc
    import hbm_pkg::*;
#(
    parameter int unsigned W  = SPEED_W,
    parameter int unsigned FS = FULL_SCALE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] step,
    output logic         wrap
);
    localparam int unsigned ACC_W = $clog2(FS);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc_q} + step[ACC_W:0];
    assign wrap = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (advance) acc_q <= sum[ACC_W-1:0];
    end

    // R7: accumulator state is retained whenever it is not advanced
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(acc_q));

    // R3: a zero step never produces a carry
    p_zero_step_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && step == '0) |-> !wrap);

endmodule

// File: rtl/hbm_mode_sel.sv
module hbm_mode_sel
    import hbm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  mix_ctrl_t ctrl,
    input  logic      at_full_scale,
    input  logic      wrap,
    output logic      advance,
    output logic      drive_on,
    output logic      full_mode
);
    mode_src_e    src;
    bridge_mode_e mode_nxt;
    bridge_mode_e mode_q;
    logic         on_q;

    always_comb begin
        if (ctrl.idle)                             src = SRC_IDLE;
        else if (ctrl.half_en && ctrl.supply_high) src = SRC_FORCED;
        else if (!ctrl.hybrid_en || at_full_scale) src = SRC_FIXED;
        else                                       src = SRC_MIX;
    end

    always_comb begin
        advance  = 1'b0;
        mode_nxt = mode_q;
        unique case (src)
            SRC_IDLE:   mode_nxt = mode_q;
            SRC_FORCED: mode_nxt = MODE_HALF;
            SRC_FIXED:  mode_nxt = MODE_FULL;
            SRC_MIX: begin
                mode_nxt = wrap ? MODE_FULL : MODE_HALF;
                advance  = tick;
            end
            default:    mode_nxt = mode_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            mode_q <= MODE_FULL;
        end else if (tick) begin
            on_q   <= (src != SRC_IDLE);
            mode_q <= mode_nxt;
        end
    end

    assign drive_on  = on_q;
    assign full_mode = (mode_q == MODE_FULL);

    // R8: outputs move only at a period boundary
    p_boundary_only_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(drive_on) && $stable(full_mode)));

    // R6: forced half-bridge wins over every mixing choice
    p_forced_half_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl.idle && ctrl.half_en && ctrl.supply_high) |=> (drive_on && !full_mode));

    // R7: idle tick switches drive off and keeps the mode
    p_idle_off_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.idle) |=> (!drive_on && full_mode == $past(full_mode)));

    // R5: mixing disabled gives full-bridge
    p_fixed_full_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl.idle && !(ctrl.half_en && ctrl.supply_high) && !ctrl.hybrid_en)
        |=> (drive_on && full_mode));

endmodule

// File: rtl/hybrid_bridge_mixer.sv
module hybrid_bridge_mixer
    import hbm_pkg::*;
#(
    parameter int unsigned W  = SPEED_W,
    parameter int unsigned FS = FULL_SCALE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         period_tick,
    input  logic         speed_we,
    input  logic [W-1:0] speed_wdata,
    input  logic         hybrid_en,
    input  logic         half_en,
    input  logic         supply_high,
    input  logic         idle,
    output logic         drive_on,
    output logic         full_mode
);
    mix_ctrl_t    ctrl;
    logic [W-1:0] speed_eff;
    logic         at_full_scale;
    logic         advance;
    logic         wrap;

    assign ctrl = '{idle: idle, half_en: half_en, supply_high: supply_high, hybrid_en: hybrid_en};

    hbm_speed_reg #(.W(W), .FS(FS)) u_speed (
        .clk           (clk),
        .rst           (rst),
        .we            (speed_we),
        .wdata         (speed_wdata),
        .speed_eff     (speed_eff),
        .at_full_scale (at_full_scale)
    );

    hbm_phase_acc #(.W(W), .FS(FS)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .step    (speed_eff),
        .wrap    (wrap)
    );

    hbm_mode_sel u_sel (
        .clk           (clk),
        .rst           (rst),
        .tick          (period_tick),
        .ctrl          (ctrl),
        .at_full_scale (at_full_scale),
        .wrap          (wrap),
        .advance       (advance),
        .drive_on      (drive_on),
        .full_mode     (full_mode)
    );

    // R4: a clamped setting never drives the accumulator
    p_clamp_no_advance_r4: assert property (@(posedge clk) disable iff (rst)
        at_full_scale |-> !advance);

endmodule

// File: tb/test_hybrid_bridge_mixer.sv
`timescale 1ns/1ps
module test_hybrid_bridge_mixer;

    typedef struct {
        logic  on;
        logic  full;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_tick = 1'b0;
    logic       speed_we = 1'b0;
    logic [7:0] speed_wdata = 8'd0;
    logic       hybrid_en = 1'b0;
    logic       half_en = 1'b0;
    logic       supply_high = 1'b0;
    logic       idle = 1'b0;
    logic       drive_on;
    logic       full_mode;

    int total = 0;
    int bad = 0;
    int full_seen = 0;
    bit finished = 1'b0;

    exp_t exp_q[$];

    // reference state
    int m_speed = 128;
    int m_acc = 0;
    logic m_full = 1'b1;

    always #2.5 clk = ~clk;

    hybrid_bridge_mixer i_hybrid_bridge_mixer (
        .clk(clk), .rst(rst), .period_tick(period_tick),
        .speed_we(speed_we), .speed_wdata(speed_wdata),
        .hybrid_en(hybrid_en), .half_en(half_en), .supply_high(supply_high),
        .idle(idle), .drive_on(drive_on), .full_mode(full_mode)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_speed(input int v);
        @(negedge clk);
        speed_we = 1'b1;
        speed_wdata = 8'(v);
        @(negedge clk);
        speed_we = 1'b0;
        m_speed = v;
    endtask

    // driver: computes expected item for one period and pulses the tick
    task automatic period(input string tag);
        exp_t e;
        int k;
        e.tag = tag;
        if (idle) begin
            e.on = 1'b0;
        end else begin
            e.on = 1'b1;
            if (half_en && supply_high) m_full = 1'b0;
            else if (!hybrid_en) m_full = 1'b1;
            else begin
                k = (m_speed > 128) ? 128 : m_speed;
                if (k == 128) m_full = 1'b1;
                else begin
                    m_acc = m_acc + k;
                    m_full = (m_acc >= 128);
                    m_acc = m_acc % 128;
                end
            end
        end
        e.full = m_full;
        @(negedge clk);
        exp_q.push_back(e);
        period_tick = 1'b1;
        @(negedge clk);
        period_tick = 1'b0;
        if (full_mode) full_seen++;
    endtask

    // monitor: after the tick edge settles, compare against the scoreboard
    always @(posedge clk) begin
        #1;
        if (period_tick && !rst) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected result", 1'b1, 1'b0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " drive_on"}, drive_on, e.on);
                check({e.tag, " full_mode"}, full_mode, e.full);
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic hold_on, hold_full;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset drive_on", drive_on, 1'b0);
        check("R1 reset full_mode", full_mode, 1'b1);

        hybrid_en = 1'b1;
        for (int i = 0; i < 6; i++) period("R1 default speed full");

        write_speed(0);
        for (int i = 0; i < 8; i++) period("R3 speed zero half");

        write_speed(64);
        for (int i = 0; i < 16; i++) period("R2 speed 64 alternate");

        write_speed(1);
        full_seen = 0;
        for (int i = 0; i < 128; i++) period("R2 speed 1 sequence");
        check_int("R2 speed 1 full count", full_seen, 1);

        write_speed(37);
        full_seen = 0;
        for (int i = 0; i < 128; i++) period("R2 speed 37 sequence");
        check_int("R2 speed 37 full count", full_seen, 37);

        write_speed(128);
        for (int i = 0; i < 6; i++) period("R3 speed 128 full");

        write_speed(200);
        for (int i = 0; i < 6; i++) period("R4 speed 200 clamped");
        write_speed(255);
        for (int i = 0; i < 4; i++) period("R4 speed 255 clamped");

        write_speed(37);
        hybrid_en = 1'b0;
        for (int i = 0; i < 6; i++) period("R5 hybrid off full");
        hybrid_en = 1'b1;
        for (int i = 0; i < 10; i++) period("R5 resume after hybrid off");

        half_en = 1'b1; supply_high = 1'b1;
        write_speed(128);
        for (int i = 0; i < 5; i++) period("R6 forced half");
        write_speed(100);
        for (int i = 0; i < 5; i++) period("R6 forced half over mix");
        supply_high = 1'b0;
        for (int i = 0; i < 6; i++) period("R6 half_en alone");
        half_en = 1'b0; supply_high = 1'b1;
        for (int i = 0; i < 6; i++) period("R6 supply_high alone");
        supply_high = 1'b0;

        idle = 1'b1;
        for (int i = 0; i < 4; i++) period("R7 idle off");
        idle = 1'b0;
        for (int i = 0; i < 12; i++) period("R7 resume after idle");

        // R8: controls move between ticks; outputs must stay put
        @(negedge clk);
        hold_on = drive_on;
        hold_full = full_mode;
        idle = 1'b1; hybrid_en = 1'b0; half_en = 1'b1; supply_high = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 drive_on stable between ticks", drive_on, hold_on);
        check("R8 full_mode stable between ticks", full_mode, hold_full);
        write_speed(9);
        idle = 1'b0; hybrid_en = 1'b1; half_en = 1'b0; supply_high = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 drive_on stable after write", drive_on, hold_on);
        check("R8 full_mode stable after write", full_mode, hold_full);
        for (int i = 0; i < 20; i++) period("R8 R2 speed 9 after gap");

        repeat (3) @(negedge clk);
        check_int("R8 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule